// File: doc/BRIEF.md
# Device Bus State Tracker

This block follows the state of a peripheral's serial-bus interface from cable attachment to full configuration, including the low-power suspended condition. It watches the bus supply indication, a bus-reset detect, a bus-activity strobe, and single-cycle completion pulses from the control-request logic: one when a set-address request has finished, and one when a set-configuration request has finished, together with the configuration value. From these inputs it keeps an encoded state and three flags for the rest of the device: suspended, address valid and configured.

The clock frequency is known. An idle timer counts clock cycles with no activity while the interface is in one of the four active states (Powered, Default, Address, Configured). If the timer reaches a limit equivalent to 3 ms, the block enters Suspended and stores the state it left. Activity then returns it to that stored state. A bus reset while suspended sends it to Default. Loss of supply overrides every other input and returns the block to Attached.

The states and their transitions are:
- Attached to Powered when the supply appears.
- Powered, Default, Address or Configured to Default on a reset.
- Default to Address on set-address.
- Address to Configured on a non-zero set-configuration.
- Configured to Address on a zero set-configuration.
- Any of the four active states to Suspended when the idle timer expires.
- Suspended to the saved state on activity.
- Suspended to Default on a reset.
- Any state to Attached on loss of supply.

Top module: `bus_state_tracker`

## Requirements
- R1: While `rst_n` is low and after its release, `state` is Attached (code 0) and `suspended`, `addr_valid` and `configured` are all 0.
- R2: The state codes are Attached=0, Powered=1, Default=2, Address=3, Configured=4 and Suspended=5. Each transition appears on `state` at the clock edge that samples its cause.
- R3: In Attached with `vbus_present` high, the next state is Powered.
- R4: With `vbus_present` high, `bus_reset` in Powered, Default, Address, Configured or Suspended gives Default at the next edge. This clears `addr_valid` and `configured`.
- R5: `set_addr_done` in Default gives Address. In any other state it is ignored.
- R6: `set_cfg_done` with a non-zero `cfg_value` in Address gives Configured. With a zero value in Address it is ignored.
- R7: `set_cfg_done` with a zero `cfg_value` in Configured gives Address. With a non-zero value the block stays in Configured.
- R8: In an active state, the block enters Suspended after IDLE_CYCLES consecutive edges on which neither `bus_activity` nor `bus_reset` is sampled high, and not sooner. IDLE_CYCLES = CLK_HZ/1e6 × IDLE_US. A request completion that arrives on the expiring edge takes priority, and the suspend follows one edge later.
- R9: `bus_activity` in Suspended (without reset) returns the block to the state held when it entered Suspended.
- R10: `vbus_present` low gives Attached at the next edge from any state, and takes priority over all other inputs.
- R11: `suspended` is 1 only in Suspended. `addr_valid` is 1 in Address or Configured, or in Suspended entered from either of them. `configured` is 1 in Configured, or in Suspended entered from it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at CLK_HZ |
| rst_n | input | 1 | Asynchronous active-low reset |
| vbus_present | input | 1 | Bus supply detected |
| bus_reset | input | 1 | Bus reset detected (level or pulse) |
| bus_activity | input | 1 | Bus traffic seen this cycle |
| set_addr_done | input | 1 | Set-address request completed (one cycle) |
| set_cfg_done | input | 1 | Set-configuration request completed (one cycle) |
| cfg_value | input | CFG_W | Configuration value carried with `set_cfg_done` |
| state | output | 3 | Encoded interface state |
| suspended | output | 1 | Interface is suspended |
| addr_valid | output | 1 | A device address has been assigned |
| configured | output | 1 | A non-zero configuration is selected |

## Verification
The hardest cases to reach are a suspend on the exact edge where the idle run completes, and a resume to a saved state deeper than Default. Both require the bench first to climb Powered, Default, Address and Configured, then to hold every strobe low for a precise number of cycles. Directed sequences do this with a reduced IDLE_CYCLES, checking one edge before the limit and the limit edge itself. Random stimulus then alternates busy stretches with long quiet ones, so that suspends begin in each active state and end by activity, reset or loss of supply.

// File: rtl/bst_pkg.sv
package bst_pkg;

    typedef enum logic [2:0] {
        ST_ATTACHED   = 3'd0,
        ST_POWERED    = 3'd1,
        ST_DEFAULT    = 3'd2,
        ST_ADDRESS    = 3'd3,
        ST_CONFIGURED = 3'd4,
        ST_SUSPENDED  = 3'd5
    } bus_state_e;

    // States in which the idle timer may run
    function automatic logic is_active(input bus_state_e s);
        return (s == ST_POWERED) || (s == ST_DEFAULT) ||
               (s == ST_ADDRESS) || (s == ST_CONFIGURED);
    endfunction

endpackage

// File: rtl/bst_idle_timer.sv
module bst_idle_timer #(
    parameter int unsigned LIMIT = 144000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic restart,
    output logic expire
);
    localparam int unsigned CW = (LIMIT < 2) ? 1 : $clog2(LIMIT);
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!enable || restart) begin
            cnt_q <= '0;
        end else if (cnt_q != LAST) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign expire = enable && !restart && (cnt_q == LAST);

endmodule

// File: rtl/bst_fsm.sv
module bst_fsm
    import bst_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       vbus_present,
    input  logic       bus_reset,
    input  logic       bus_activity,
    input  logic       set_addr_done,
    input  logic       set_cfg_done,
    input  logic       cfg_nonzero,
    input  logic       idle_expire,
    output bus_state_e state_q,
    output bus_state_e saved_q
);
    bus_state_e state_d;
    bus_state_e saved_d;

    always_comb begin
        state_d = state_q;
        saved_d = saved_q;
        if (!vbus_present) begin
            state_d = ST_ATTACHED;
        end else begin
            unique case (state_q)
                ST_ATTACHED: state_d = ST_POWERED;
                ST_POWERED: begin
                    if (bus_reset)        state_d = ST_DEFAULT;
                    else if (idle_expire) state_d = ST_SUSPENDED;
                end
                ST_DEFAULT: begin
                    if (bus_reset)          state_d = ST_DEFAULT;
                    else if (set_addr_done) state_d = ST_ADDRESS;
                    else if (idle_expire)   state_d = ST_SUSPENDED;
                end
                ST_ADDRESS: begin
                    if (bus_reset)                        state_d = ST_DEFAULT;
                    else if (set_cfg_done && cfg_nonzero) state_d = ST_CONFIGURED;
                    else if (idle_expire)                 state_d = ST_SUSPENDED;
                end
                ST_CONFIGURED: begin
                    if (bus_reset)                         state_d = ST_DEFAULT;
                    else if (set_cfg_done && !cfg_nonzero) state_d = ST_ADDRESS;
                    else if (idle_expire)                  state_d = ST_SUSPENDED;
                end
                ST_SUSPENDED: begin
                    if (bus_reset)         state_d = ST_DEFAULT;
                    else if (bus_activity) state_d = saved_q;
                end
                default: state_d = ST_ATTACHED;
            endcase
        end
        if (state_d == ST_SUSPENDED && state_q != ST_SUSPENDED) begin
            saved_d = state_q;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_ATTACHED;
            saved_q <= ST_ATTACHED;
        end else begin
            state_q <= state_d;
            saved_q <= saved_d;
        end
    end

endmodule

// File: rtl/bst_flags.sv
module bst_flags
    import bst_pkg::*;
(
    input  bus_state_e state_q,
    input  bus_state_e saved_q,
    output logic       suspended,
    output logic       addr_valid,
    output logic       configured
);
    always_comb begin
        suspended  = 1'b0;
        addr_valid = 1'b0;
        configured = 1'b0;
        unique case (state_q)
            ST_ADDRESS: addr_valid = 1'b1;
            ST_CONFIGURED: begin
                addr_valid = 1'b1;
                configured = 1'b1;
            end
            ST_SUSPENDED: begin
                suspended  = 1'b1;
                addr_valid = (saved_q == ST_ADDRESS) || (saved_q == ST_CONFIGURED);
                configured = (saved_q == ST_CONFIGURED);
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/bus_state_tracker.sv
module bus_state_tracker
    import bst_pkg::*;
#(
    parameter int unsigned CLK_HZ  = 48_000_000,
    parameter int unsigned IDLE_US = 3000,
    parameter int unsigned CFG_W   = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             vbus_present,
    input  logic             bus_reset,
    input  logic             bus_activity,
    input  logic             set_addr_done,
    input  logic             set_cfg_done,
    input  logic [CFG_W-1:0] cfg_value,
    output logic [2:0]       state,
    output logic             suspended,
    output logic             addr_valid,
    output logic             configured
);
    localparam int unsigned IDLE_CYCLES = (CLK_HZ / 1_000_000) * IDLE_US;

    bus_state_e state_q;
    bus_state_e saved_q;
    logic       idle_expire;

    bst_idle_timer #(.LIMIT(IDLE_CYCLES)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .enable  (is_active(state_q)),
        .restart (bus_activity || bus_reset),
        .expire  (idle_expire)
    );

    bst_fsm u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .vbus_present  (vbus_present),
        .bus_reset     (bus_reset),
        .bus_activity  (bus_activity),
        .set_addr_done (set_addr_done),
        .set_cfg_done  (set_cfg_done),
        .cfg_nonzero   (|cfg_value),
        .idle_expire   (idle_expire),
        .state_q       (state_q),
        .saved_q       (saved_q)
    );

    bst_flags u_flags (
        .state_q    (state_q),
        .saved_q    (saved_q),
        .suspended  (suspended),
        .addr_valid (addr_valid),
        .configured (configured)
    );

    assign state = state_q;

endmodule

// File: rtl/bst_chk.sv
module bst_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       vbus_present,
    input logic       bus_reset,
    input logic       bus_activity,
    input logic [2:0] state,
    input logic       suspended,
    input logic       addr_valid,
    input logic       configured
);
    // R10
    vbus_loss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !vbus_present |=> state == 3'd0);

    // R4
    reset_default_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (vbus_present && bus_reset && state != 3'd0) |=>
            (state == 3'd2 && !addr_valid && !configured));

    // R9
    resume_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (vbus_present && !bus_reset && bus_activity && suspended) |=>
            (!suspended && state >= 3'd1 && state <= 3'd4));

    // R8
    activity_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (vbus_present && bus_activity && !suspended) |=> !suspended);

    // R11
    cfg_implies_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        configured |-> addr_valid);

    // R3
    attach_power_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == 3'd0 && vbus_present) |=> state == 3'd1);
endmodule

bind bus_state_tracker bst_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .vbus_present (vbus_present),
    .bus_reset    (bus_reset),
    .bus_activity (bus_activity),
    .state        (state),
    .suspended    (suspended),
    .addr_valid   (addr_valid),
    .configured   (configured)
);

// File: tb/bus_state_tracker_test.sv
`timescale 1ns/1ps
module bus_state_tracker_test;
    localparam int CLK_HZ = 20_000_000;
    localparam int IDLE_US = 1;
    localparam int LIMIT = (CLK_HZ / 1_000_000) * IDLE_US;

    logic clk = 0;
    logic rst_n = 0;
    logic vbus = 0, rst_bus = 0, act = 0, sa = 0, sc = 0;
    logic [7:0] cv = 0;
    logic [2:0] state;
    logic suspended, addr_valid, configured;

    int n_tests = 0, n_fail = 0;
    int e_state = 0, e_saved = 0, e_run = 0;

    always #4 clk = ~clk;

    bus_state_tracker #(.CLK_HZ(CLK_HZ), .IDLE_US(IDLE_US), .CFG_W(8)) uut (
        .clk(clk), .rst_n(rst_n), .vbus_present(vbus), .bus_reset(rst_bus),
        .bus_activity(act), .set_addr_done(sa), .set_cfg_done(sc), .cfg_value(cv),
        .state(state), .suspended(suspended), .addr_valid(addr_valid),
        .configured(configured)
    );

    function automatic bit active(int s);
        return s >= 1 && s <= 4;
    endfunction

    // Reference model, updated once per clock edge from the sampled inputs
    task automatic model_edge();
        int nxt = e_state;
        bit expire = active(e_state) && !act && !rst_bus && (e_run + 1 >= LIMIT);
        if (!vbus) nxt = 0;
        else case (e_state)
            0: nxt = 1;
            1: if (rst_bus) nxt = 2; else if (expire) nxt = 5;
            2: if (rst_bus) nxt = 2; else if (sa) nxt = 3; else if (expire) nxt = 5;
            3: if (rst_bus) nxt = 2; else if (sc && cv != 0) nxt = 4; else if (expire) nxt = 5;
            4: if (rst_bus) nxt = 2; else if (sc && cv == 0) nxt = 3; else if (expire) nxt = 5;
            5: if (rst_bus) nxt = 2; else if (act) nxt = e_saved;
            default: nxt = 0;
        endcase
        if (!active(e_state) || act || rst_bus) e_run = 0;
        else e_run = e_run + 1;
        if (nxt == 5 && e_state != 5) e_saved = e_state;
        e_state = nxt;
    endtask

    task automatic compare(string tag);
        int ea = (e_state == 3 || e_state == 4 || (e_state == 5 && (e_saved == 3 || e_saved == 4)));
        int ec = (e_state == 4 || (e_state == 5 && e_saved == 4));
        int es = (e_state == 5);
        n_tests++;
        if (state !== 3'(e_state) || suspended !== 1'(es) ||
            addr_valid !== 1'(ea) || configured !== 1'(ec)) begin
            n_fail++;
            $display("FAIL %s: got st=%0d sus=%0b adr=%0b cfg=%0b exp st=%0d sus=%0b adr=%0b cfg=%0b",
                     tag, state, suspended, addr_valid, configured, e_state, es, ea, ec);
        end
    endtask

    task automatic step(bit v, bit r, bit a, bit s_a, bit s_c, logic [7:0] val, string tag);
        @(negedge clk);
        vbus = v; rst_bus = r; act = a; sa = s_a; sc = s_c; cv = val;
        @(posedge clk);
        model_edge();
        #1;
        compare(tag);
    endtask

    task automatic expect_state(int exp, string tag);
        n_tests++;
        if (state !== 3'(exp)) begin
            n_fail++;
            $display("FAIL %s: got state=%0d exp=%0d", tag, state, exp);
        end
    endtask

    initial begin
        #200000000;
        n_tests++; n_fail++;
        $display("FAIL watchdog: got timeout exp completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        repeat (3) @(posedge clk);
        #1 compare("R1 reset held");
        @(negedge clk) rst_n = 1;
        step(0,0,0,0,0,0,"R1 after reset");
        expect_state(0, "R1 attached");

        step(1,0,1,0,0,0,"R3 power");               expect_state(1, "R3");
        step(1,0,1,1,0,0,"R5 addr ignored in powered"); expect_state(1, "R5 ignored");
        step(1,1,0,0,0,0,"R4 reset to default");    expect_state(2, "R4");
        step(1,0,1,0,1,8'd3,"R6 cfg ignored in default"); expect_state(2, "R6 ignored");
        step(1,0,1,1,0,0,"R5 address");             expect_state(3, "R5");
        step(1,0,1,0,1,8'd0,"R6 zero cfg ignored"); expect_state(3, "R6 zero");
        step(1,0,1,0,1,8'd7,"R6 configured");       expect_state(4, "R6");
        step(1,0,1,0,1,8'd9,"R7 nonzero stays");    expect_state(4, "R7 stay");
        step(1,0,1,0,1,8'd0,"R7 back to address");  expect_state(3, "R7");
        step(1,0,1,0,1,8'd1,"R6 reconfigure");      expect_state(4, "R6 again");

        // R8 boundary: activity edge, then LIMIT-1 idle edges stay active
        for (int i = 0; i < LIMIT - 1; i++) step(1,0,0,0,0,0,"R8 idle run");
        expect_state(4, "R8 one before limit");
        step(1,0,0,0,0,0,"R8 limit edge");
        expect_state(5, "R8 suspend at limit");
        n_tests++;
        if (!(addr_valid && configured)) begin
            n_fail++;
            $display("FAIL R11: got adr=%0b cfg=%0b exp 1 1", addr_valid, configured);
        end
        step(1,0,0,0,0,0,"R8 stays suspended");
        step(1,0,1,0,0,0,"R9 resume");              expect_state(4, "R9 resume to configured");

        for (int i = 0; i < LIMIT; i++) step(1,0,0,0,0,0,"R8 idle again");
        expect_state(5, "R8 second suspend");
        step(1,1,1,0,0,0,"R4 reset in suspend");    expect_state(2, "R4 suspend reset");
        for (int i = 0; i < LIMIT; i++) step(1,0,0,0,0,0,"R8 idle default");
        step(0,1,1,0,0,0,"R10 vbus loss");          expect_state(0, "R10");

        // Random phase: alternating busy and quiet stretches
        for (int blk = 0; blk < 150; blk++) begin
            bit quiet = ($urandom % 3) == 0;
            int len = quiet ? LIMIT + ($urandom % 8) - 4 : 10 + ($urandom % 20);
            for (int i = 0; i < len; i++) begin
                bit v  = ($urandom % 200) != 0;
                bit r  = !quiet && ($urandom % 40) == 0;
                bit a  = !quiet && ($urandom % 2) == 0;
                bit s1 = ($urandom % 6) == 0;
                bit s2 = ($urandom % 6) == 0;
                logic [7:0] val = 8'($urandom % 3);
                step(v, r, a, s1, s2, val, "R2 R8 R9 R10 R11 random");
            end
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule